// File: doc/BRIEF.md
# Paired Word FIFOs with Threshold Flags

This block sits between a register bus and a serial shifter and holds two queues of 32-bit words, eight entries each. The outbound queue takes words pushed from the bus and gives them up to the shifter. The inbound queue takes words pushed by the shifter and gives them up to the bus. Both queues report full, empty and a ready flag. The ready flag is set by comparing occupancy (inbound) or free space (outbound) against a 3-bit threshold that software programs. Both queues also report sticky error flags: one for a push that was refused and one for a pop that found no data.

Software empties both queues with a one-shot flush request, then polls a busy bit until the hardware clears it. A level-sensitive soft reset holds the whole block in its reset state for as long as it is asserted. All flags are gathered into one status word at fixed bit positions, so a register decoder can map that word directly.

Top module: `spi_word_fifos`

## Requirements
- R1: Each queue returns words in the order they were pushed. A successful pop places the head word on that queue's data output after the clock edge that takes the pop, and the output holds that word until the next successful pop.
- R2: Status bit 7 is outbound full and bit 6 is outbound empty. Bit 5 is inbound full and bit 4 is inbound empty. Full means 8 entries and empty means 0 entries.
- R3: Status bit 2 (inbound ready) is 1 exactly when inbound occupancy is greater than `rd_thresh`. Status bit 3 (outbound ready) is 1 exactly when outbound free space (8 minus occupancy) is greater than `wr_thresh`.
- R4: A push into a full queue drops the word and leaves the contents unchanged. It sets bit 11 for the outbound queue or bit 9 for the inbound queue.
- R5: A pop from an empty queue leaves the data output at its previous value. It sets bit 10 for the outbound queue or bit 8 for the inbound queue.
- R6: Bits 11 to 8 stay set until a flush completes or a soft reset is applied.
- R7: A `flush_req` pulse sets `flush_busy` after the next edge. At the edge after that, both queues empty, bits 11 to 8 clear and `flush_busy` returns to 0. Pushes, pops and a new request that arrive while `flush_busy` is 1 are ignored. The data outputs keep their values.
- R8: While `soft_rst` is 1, and after `rst_n` is low, both queues are empty, all error bits and `flush_busy` are 0, and both data outputs are 0. With the default depth the status word reads 0x058.
- R9: When a push and a pop reach the same queue in one cycle, each is judged on the occupancy at the start of that cycle. A pop from a full queue with a simultaneous push leaves 7 entries and flags an overflow. A push into an empty queue with a simultaneous pop flags an underflow and leaves 1 entry.
- R10: Status bits 1 and 0 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous reset, held active high |
| flush_req | input | 1 | Request to empty both queues |
| flush_busy | output | 1 | Flush pending; clears itself |
| wr_thresh | input | 3 | Outbound ready threshold on free space |
| rd_thresh | input | 3 | Inbound ready threshold on occupancy |
| bus_wr_en | input | 1 | Bus push into outbound queue |
| bus_wr_data | input | 32 | Word pushed by the bus |
| bus_rd_en | input | 1 | Bus pop from inbound queue |
| bus_rd_data | output | 32 | Last word popped by the bus |
| shf_rd_en | input | 1 | Shifter pop from outbound queue |
| shf_rd_data | output | 32 | Last word popped by the shifter |
| shf_wr_en | input | 1 | Shifter push into inbound queue |
| shf_wr_data | input | 32 | Word pushed by the shifter |
| status | output | 12 | Flag word (bits 11 to 2 as listed above) |

## Verification
The bench targets the edges of occupancy. It pushes into a full queue and pops from an empty one, alone and together with the opposite operation in the same cycle. A design that judges fullness after the pop would accept a word it should drop, and one that wraps its pointers wrongly would return words out of order. It sweeps both thresholds across their range, so an off-by-one in the ready comparison shows up as a ready flag one entry early or late. It issues flushes during traffic and while a flush is already pending, and holds the soft reset mid-stream. A flush that took effect at once, cleared errors too early, or let a word slip in during the busy cycle would show up on the next status or data comparison.

// File: rtl/spi_word_fifos.sv
module spi_word_fifos #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  parameter int TW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          flush_req,
  output logic          flush_busy,
  input  logic [TW-1:0] wr_thresh,
  input  logic [TW-1:0] rd_thresh,
  input  logic          bus_wr_en,
  input  logic [DW-1:0] bus_wr_data,
  input  logic          bus_rd_en,
  output logic [DW-1:0] bus_rd_data,
  input  logic          shf_rd_en,
  output logic [DW-1:0] shf_rd_data,
  input  logic          shf_wr_en,
  input  logic [DW-1:0] shf_wr_data,
  output logic [11:0]   status
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULLN = CW'(DEPTH);
  localparam logic [AW-1:0] LASTP = AW'(DEPTH - 1);

  logic          flush_q;
  logic [1:0]    push, pop, full, empty, ovf, unf, rdy;
  logic [DW-1:0] din  [2];
  logic [DW-1:0] dout [2];

  assign push    = {shf_wr_en, bus_wr_en};
  assign pop     = {bus_rd_en, shf_rd_en};
  assign din[0]  = bus_wr_data;
  assign din[1]  = shf_wr_data;
  assign shf_rd_data = dout[0];
  assign bus_rd_data = dout[1];
  assign flush_busy  = flush_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  flush_q <= 1'b0;
    else if (soft_rst || flush_q) flush_q <= 1'b0;
    else                         flush_q <= flush_req;

  for (genvar g = 0; g < 2; g++) begin : g_q
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] n;
    logic          o, u;
    logic [DW-1:0] q;
    logic          do_push, do_pop, hold;

    assign full[g]  = (n == FULLN);
    assign empty[g] = (n == '0);
    assign hold     = soft_rst | flush_q;
    assign do_push  = push[g] & ~full[g] & ~hold;
    assign do_pop   = pop[g] & ~empty[g] & ~hold;
    assign ovf[g]   = o;
    assign unf[g]   = u;
    assign dout[g]  = q;

    if (g == 0) begin : g_out
      assign rdy[g] = (FULLN - n) > CW'(wr_thresh);
    end else begin : g_in
      assign rdy[g] = n > CW'(rd_thresh);
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        wp <= '0; rp <= '0; n <= '0; o <= 1'b0; u <= 1'b0; q <= '0;
      end else if (soft_rst) begin
        wp <= '0; rp <= '0; n <= '0; o <= 1'b0; u <= 1'b0; q <= '0;
      end else if (flush_q) begin
        wp <= '0; rp <= '0; n <= '0; o <= 1'b0; u <= 1'b0;
      end else begin
        if (do_push) wp <= (wp == LASTP) ? '0 : wp + 1'b1;
        if (do_pop) begin
          rp <= (rp == LASTP) ? '0 : rp + 1'b1;
          q  <= mem[rp];
        end
        n <= n + CW'(do_push) - CW'(do_pop);
        o <= o | (push[g] & full[g]);
        u <= u | (pop[g] & empty[g]);
      end

    always_ff @(posedge clk)
      if (do_push) mem[wp] <= din[g];
  end

  assign status = {ovf[0], unf[0], ovf[1], unf[1],
                   full[0], empty[0], full[1], empty[1],
                   rdy[0], rdy[1], 2'b00};
endmodule

module spi_word_fifos_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        soft_rst,
  input logic        flush_busy,
  input logic        bus_wr_en,
  input logic        bus_rd_en,
  input logic [31:0] bus_rd_data,
  input logic [11:0] status
);
  // R2
  full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[7] && status[6]) && !(status[5] && status[4]));
  // R4
  wr_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && status[7] && !soft_rst && !flush_busy) |=> status[11]);
  // R5
  rd_underflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && status[4] && !soft_rst && !flush_busy) |=> (status[8] && $stable(bus_rd_data)));
  // R6
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && !flush_busy) |=> ((status[11:8] & $past(status[11:8])) == $past(status[11:8])));
  // R7
  flush_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_busy |=> !flush_busy);
  // R7
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_busy && !soft_rst) |=> (status[6] && status[4] && status[11:8] == 4'h0));
  // R8
  soft_reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (status == 12'h058 && !flush_busy && bus_rd_data == 32'h0));
  // R10
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[1:0] == 2'b00);
endmodule

bind spi_word_fifos spi_word_fifos_chk u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .flush_busy(flush_busy),
  .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en), .bus_rd_data(bus_rd_data),
  .status(status)
);

// File: tb/spi_word_fifos_tb_top.sv
`timescale 1ns/1ps
module spi_word_fifos_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0, flush_req = 1'b0;
  logic        flush_busy;
  logic [2:0]  wr_thresh = 3'd0, rd_thresh = 3'd0;
  logic        bus_wr_en = 1'b0, bus_rd_en = 1'b0, shf_rd_en = 1'b0, shf_wr_en = 1'b0;
  logic [31:0] bus_wr_data = '0, shf_wr_data = '0;
  logic [31:0] bus_rd_data, shf_rd_data;
  logic [11:0] status;

  int checks = 0, fails = 0, cycles = 0;

  always #4 clk = ~clk;

  spi_word_fifos dut_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .flush_req(flush_req),
    .flush_busy(flush_busy), .wr_thresh(wr_thresh), .rd_thresh(rd_thresh),
    .bus_wr_en(bus_wr_en), .bus_wr_data(bus_wr_data), .bus_rd_en(bus_rd_en),
    .bus_rd_data(bus_rd_data), .shf_rd_en(shf_rd_en), .shf_rd_data(shf_rd_data),
    .shf_wr_en(shf_wr_en), .shf_wr_data(shf_wr_data), .status(status)
  );

  // reference model
  logic [31:0] oq[$], iq[$];
  logic        m_wov, m_wun, m_rov, m_run, m_busy;
  logic [31:0] m_sdo, m_bdo;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [11:0] model_status();
    logic [11:0] s;
    s = '0;
    s[11] = m_wov; s[10] = m_wun; s[9] = m_rov; s[8] = m_run;
    s[7] = (oq.size() == 8); s[6] = (oq.size() == 0);
    s[5] = (iq.size() == 8); s[4] = (iq.size() == 0);
    s[3] = (8 - oq.size()) > int'(wr_thresh);
    s[2] = iq.size() > int'(rd_thresh);
    return s;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || soft_rst) begin
      oq.delete(); iq.delete();
      m_wov = 0; m_wun = 0; m_rov = 0; m_run = 0; m_busy = 0; m_sdo = '0; m_bdo = '0;
    end else if (m_busy) begin
      oq.delete(); iq.delete();
      m_wov = 0; m_wun = 0; m_rov = 0; m_run = 0; m_busy = 0;
    end else begin
      int os, is;
      os = oq.size(); is = iq.size();
      m_busy = flush_req;
      if (shf_rd_en) begin
        if (os == 0) m_wun = 1; else m_sdo = oq.pop_front();
      end
      if (bus_wr_en) begin
        if (os == 8) m_wov = 1; else oq.push_back(bus_wr_data);
      end
      if (bus_rd_en) begin
        if (is == 0) m_run = 1; else m_bdo = iq.pop_front();
      end
      if (shf_wr_en) begin
        if (is == 8) m_rov = 1; else iq.push_back(shf_wr_data);
      end
    end
    if (rst_n && $time > 0) begin
      logic [11:0] e;
      #2;
      e = model_status();
      chk("R1/R5 bus data", bus_rd_data, m_bdo);
      chk("R1/R5 shifter data", shf_rd_data, m_sdo);
      chk("R2 full/empty", {28'h0, status[7:4]}, {28'h0, e[7:4]});
      chk("R3 ready", {30'h0, status[3:2]}, {30'h0, e[3:2]});
      chk("R4/R9 overflow", {30'h0, status[11], status[9]}, {30'h0, e[11], e[9]});
      chk("R5/R9 underflow", {30'h0, status[10], status[8]}, {30'h0, e[10], e[8]});
      chk("R7 flush busy", {31'h0, flush_busy}, {31'h0, m_busy});
      chk("R10 low bits", {30'h0, status[1:0]}, 32'h0);
    end
  end

  task automatic idle();
    bus_wr_en = 0; bus_rd_en = 0; shf_rd_en = 0; shf_wr_en = 0;
    flush_req = 0; soft_rst = 0;
  endtask

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_flush();
    idle(); flush_req = 1; cyc(); flush_req = 0;
    chk("R7 busy after request", {31'h0, flush_busy}, 32'h1);
    cyc();
    chk("R7 busy self-clears", {31'h0, flush_busy}, 32'h0);
  endtask

  task automatic rand_phase(input int n, input int pbw, input int psr, input int psw, input int pbr);
    for (int i = 0; i < n; i++) begin
      bus_wr_en = ($urandom % 100) < pbw;
      shf_rd_en = ($urandom % 100) < psr;
      shf_wr_en = ($urandom % 100) < psw;
      bus_rd_en = ($urandom % 100) < pbr;
      bus_wr_data = $urandom; shf_wr_data = $urandom;
      flush_req = ($urandom % 100) < 2;
      soft_rst  = ($urandom % 200) < 1;
      if (($urandom % 50) == 0) begin wr_thresh = 3'($urandom); rd_thresh = 3'($urandom); end
      cyc();
    end
    idle();
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    chk("R8 reset status", {20'h0, status}, 32'h058);
    chk("R8 reset data", bus_rd_data, 32'h0);

    // R4: fill outbound and one extra push
    for (int i = 0; i < 9; i++) begin
      bus_wr_en = 1; bus_wr_data = 32'hA000_0000 + i; cyc();
    end
    idle(); cyc();
    chk("R4 overflow bit", {31'h0, status[11]}, 32'h1);
    chk("R2 outbound full", {31'h0, status[7]}, 32'h1);
    cyc(3);
    chk("R6 overflow sticky", {31'h0, status[11]}, 32'h1);

    // R1: drain in order
    for (int i = 0; i < 8; i++) begin
      shf_rd_en = 1; cyc(); idle();
      chk("R1 order", shf_rd_data, 32'hA000_0000 + i);
    end
    shf_rd_en = 1; cyc(); idle();
    chk("R5 hold on empty", shf_rd_data, 32'hA000_0007);
    chk("R5 underflow bit", {31'h0, status[10]}, 32'h1);

    // R7: request during busy is ignored; traffic during busy ignored
    flush_req = 1; cyc();
    chk("R7 busy", {31'h0, flush_busy}, 32'h1);
    flush_req = 1; bus_wr_en = 1; bus_wr_data = 32'h5555_5555; cyc(); idle();
    chk("R7 cleared and empty", {20'h0, status}, 32'h058);
    cyc();
    chk("R7 no retrigger", {31'h0, flush_busy}, 32'h0);

    // R3: inbound threshold
    rd_thresh = 3'd2;
    for (int i = 0; i < 2; i++) begin shf_wr_en = 1; shf_wr_data = 32'hB0 + i; cyc(); end
    idle(); cyc();
    chk("R3 not ready at threshold", {31'h0, status[2]}, 32'h0);
    shf_wr_en = 1; shf_wr_data = 32'hB2; cyc(); idle();
    chk("R3 ready above threshold", {31'h0, status[2]}, 32'h1);

    // R9: full inbound, simultaneous pop and push
    for (int i = 3; i < 8; i++) begin shf_wr_en = 1; shf_wr_data = 32'hB0 + i; cyc(); end
    shf_wr_en = 1; bus_rd_en = 1; shf_wr_data = 32'hDEAD; cyc(); idle();
    chk("R9 overflow with pop", {31'h0, status[9]}, 32'h1);
    chk("R9 one left free", {31'h0, status[5]}, 32'h0);
    do_flush();

    // R9: empty outbound, simultaneous push and pop
    bus_wr_en = 1; shf_rd_en = 1; bus_wr_data = 32'h1234; cyc(); idle();
    chk("R9 underflow with push", {31'h0, status[10]}, 32'h1);
    chk("R9 word kept", {31'h0, status[6]}, 32'h0);

    // R8: soft reset mid-stream
    soft_rst = 1; cyc(2); soft_rst = 0;
    chk("R8 soft reset status", {20'h0, status}, 32'h058);
    chk("R8 soft reset data", shf_rd_data, 32'h0);

    // R3 outbound threshold
    wr_thresh = 3'd7; cyc();
    chk("R3 write ready max free", {31'h0, status[3]}, 32'h1);
    bus_wr_en = 1; cyc(); idle();
    chk("R3 write not ready", {31'h0, status[3]}, 32'h0);

    rand_phase(3000, 70, 30, 70, 30);
    rand_phase(3000, 30, 70, 30, 70);
    rand_phase(4000, 50, 50, 50, 50);
    rand_phase(2000, 90, 10, 10, 90);
    cyc(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule